// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block carries out the memory and register traffic needed to enter and leave an interrupt handler. When an entry request arrives, it takes the interrupt index, a 64-bit auxiliary argument, the handler address and the return address of the interrupted program. It writes a fixed 36-word context record onto an upward-growing stack and then loads the handler's arguments and start address into the register file. When a return request arrives, it rebuilds the stack pointer from the frame pointer and reads the record back in the opposite order. Each word it reads is written straight into its register.

Memory is reached through one 64-bit request port. A request stays asserted, with its address unchanged, until the ready input accepts it. The register file is reached through one combinational read port and one write strobe. Register selectors are 6 bits wide: 0 to 31 name the general registers R0 to R31, 32 names the frame pointer, 33 the flag register, 34 the status register, 35 the stack pointer and 36 the instruction pointer. A one-cycle start pulse launches a sequence and a one-cycle done pulse ends it. Vector lookup, masking and fault escalation are left to the surrounding logic.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, and at all times while idle, `busy`, `done`, `mem_req` and `rf_we` are low.
- R2: An entry reads the stack pointer (selector 35) once. It then issues 36 memory writes (`mem_we`=1) at consecutive ascending 8-byte addresses, starting at that stack pointer value. The words written are, in order: the frame pointer (selector 32), `next_ip`, the flag register (33), the status register (34), then R0 up to R31 (selectors 0 to 31).
- R3: Once the last save is accepted, an entry performs five register writes, one per cycle, in this order: stack pointer ← old stack pointer + 288; frame pointer ← that new stack pointer − 288; instruction pointer (36) ← `handler_addr`; R0 ← `irq_index` zero-extended to 64 bits; R1 ← `irq_aux`. No register is written before the last save is accepted.
- R4: A return sets its working stack pointer to the frame pointer + 288. It then issues 36 memory reads (`mem_we`=0) at descending addresses, the first at frame pointer + 280. In the cycle each read is accepted, the word read is written to R31, R30, … R0, then to the status register, the flag register, the instruction pointer and the frame pointer, in that order. A final write sets the stack pointer to the original frame pointer value.
- R5: While `mem_ready` is low, `mem_req` stays high and `mem_addr` and `mem_we` hold their values. The sequence does not advance.
- R6: `busy` is high from the cycle after a start is accepted until the end of the done cycle. `done` is high for exactly one cycle, after the final register write, and the block is idle in the next cycle.
- R7: A start pulse on either input while `busy` is high is ignored. The traffic of the current sequence is unchanged and no further sequence follows it.
- R8: When `entry_start` and `ret_start` are both high in an idle cycle, an entry is performed and the return request is dropped.
- R9: Entries nest. A second entry made while a handler runs places its record directly above the first. Two returns then restore every register to its value before the first entry, except the instruction pointer, which takes the first entry's `next_ip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_start | input | 1 | Start an interrupt entry |
| ret_start | input | 1 | Start an interrupt return |
| irq_index | input | IDX_W | Interrupt index, loaded into R0 |
| irq_aux | input | 64 | Auxiliary argument, loaded into R1 |
| handler_addr | input | 64 | Handler start address |
| next_ip | input | 64 | Return address saved in the record |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the access |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid while the read is requested |
| mem_ready | input | 1 | Accepts the current request |
| rf_raddr | output | 6 | Register file read selector |
| rf_rdata | input | 64 | Register file read data |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 6 | Register file write selector |
| rf_wdata | output | 64 | Register file write data |

## Verification
The hardest situation to reach is a return that unwinds nested frames while memory stalls at random. Here the decreasing pointer and the register selector must stay in step through held requests. A second hazard is a start pulse that lands in the middle of a 36-beat save. The stimulus builds two nested entries and two returns under a pseudo-random ready pattern, and it injects start pulses on both inputs a few beats into a save. A return from a record planted directly in memory then checks the pop order against data the bench chose itself.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    localparam int XLEN        = 64;
    localparam int WORD_BYTES  = XLEN / 8;
    localparam int NUM_GPR     = 32;
    localparam int CTRL_SLOTS  = 4;
    localparam int FRAME_WORDS = NUM_GPR + CTRL_SLOTS;
    localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
    localparam int SEL_W       = 6;
    localparam int SLOT_W      = $clog2(FRAME_WORDS);
    localparam int SLOT_RET    = 1;

    typedef logic [SEL_W-1:0] rsel_t;

    localparam rsel_t SEL_FP     = 6'd32;
    localparam rsel_t SEL_FLAGS  = 6'd33;
    localparam rsel_t SEL_STATUS = 6'd34;
    localparam rsel_t SEL_SP     = 6'd35;
    localparam rsel_t SEL_IP     = 6'd36;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_E_SP,
        ST_E_PUSH,
        ST_E_SETSP,
        ST_E_SETFP,
        ST_E_SETIP,
        ST_E_SETR0,
        ST_E_SETR1,
        ST_R_FP,
        ST_R_POP,
        ST_R_SETSP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic             we;
        rsel_t            sel;
        logic [XLEN-1:0]  data;
    } rf_wr_t;

    // Record slot -> register selector. Slot 0 is the lowest address.
    function automatic rsel_t slot_sel(input logic [SLOT_W-1:0] slot);
        case (slot)
            SLOT_W'(0): slot_sel = SEL_FP;
            SLOT_W'(1): slot_sel = SEL_IP;
            SLOT_W'(2): slot_sel = SEL_FLAGS;
            SLOT_W'(3): slot_sel = SEL_STATUS;
            default:    slot_sel = rsel_t'(slot - SLOT_W'(CTRL_SLOTS));
        endcase
    endfunction

endpackage

// File: rtl/irq_ctx_beat.sv
module irq_ctx_beat #(
    parameter int COUNT = 36,
    parameter int W     = $clog2(COUNT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         last
);

    assign last = (cnt == W'(COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + W'(1);
    end

    p_beat_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(COUNT - 1));

endmodule

// File: rtl/irq_ctx_sp.sv
module irq_ctx_sp #(
    parameter int W    = 64,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         up,
    input  logic         down,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_below
);

    always_ff @(posedge clk) begin
        if (rst)
            sp <= '0;
        else if (load)
            sp <= load_val;
        else if (up)
            sp <= sp + W'(STEP);
        else if (down)
            sp <= sp - W'(STEP);
    end

    assign sp_below = sp - W'(STEP);

    // Control never asks for two pointer operations in one cycle (R2, R4).
    p_sp_one_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({load, up, down}) <= 1);

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  entry_start,
    input  logic                  ret_start,
    input  logic [IDX_W-1:0]      irq_index,
    input  logic [XLEN-1:0]       irq_aux,
    input  logic [XLEN-1:0]       handler_addr,
    input  logic [XLEN-1:0]       next_ip,
    output logic                  busy,
    output logic                  done,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [XLEN-1:0]       mem_addr,
    output logic [XLEN-1:0]       mem_wdata,
    input  logic [XLEN-1:0]       mem_rdata,
    input  logic                  mem_ready,
    output logic [SEL_W-1:0]      rf_raddr,
    input  logic [XLEN-1:0]       rf_rdata,
    output logic                  rf_we,
    output logic [SEL_W-1:0]      rf_waddr,
    output logic [XLEN-1:0]       rf_wdata
);

    localparam logic [XLEN-1:0] FRAME_SPAN = XLEN'(FRAME_BYTES);
    localparam logic [XLEN-1:0] WORD_STEP  = XLEN'(WORD_BYTES);

    seq_state_e            state_q, state_d;
    logic [IDX_W-1:0]      idx_q;
    logic [XLEN-1:0]       aux_q, hnd_q, nip_q;
    logic [SLOT_W-1:0]     beat_cnt;
    logic                  beat_last;
    logic                  beat_clr, beat_step;
    logic                  sp_load, sp_up, sp_down;
    logic [XLEN-1:0]       sp_load_val, sp_cur, sp_below;
    rf_wr_t                wr;
    logic                  accept;

    assign accept = (state_q == ST_IDLE) && (entry_start || ret_start);

    // Argument capture on acceptance only; later pulses are ignored.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            aux_q <= '0;
            hnd_q <= '0;
            nip_q <= '0;
        end else if (accept && entry_start) begin
            idx_q <= irq_index;
            aux_q <= irq_aux;
            hnd_q <= handler_addr;
            nip_q <= next_ip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (entry_start)    state_d = ST_E_SP;
                else if (ret_start) state_d = ST_R_FP;
            end
            ST_E_SP:    state_d = ST_E_PUSH;
            ST_E_PUSH:  if (mem_ready && beat_last) state_d = ST_E_SETSP;
            ST_E_SETSP: state_d = ST_E_SETFP;
            ST_E_SETFP: state_d = ST_E_SETIP;
            ST_E_SETIP: state_d = ST_E_SETR0;
            ST_E_SETR0: state_d = ST_E_SETR1;
            ST_E_SETR1: state_d = ST_DONE;
            ST_R_FP:    state_d = ST_R_POP;
            ST_R_POP:   if (mem_ready && beat_last) state_d = ST_R_SETSP;
            ST_R_SETSP: state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Memory port
    assign mem_req   = (state_q == ST_E_PUSH) || (state_q == ST_R_POP);
    assign mem_we    = (state_q == ST_E_PUSH);
    assign mem_addr  = (state_q == ST_R_POP) ? sp_below : sp_cur;
    assign mem_wdata = (beat_cnt == SLOT_W'(SLOT_RET)) ? nip_q : rf_rdata;

    // Pointer and beat control
    assign beat_clr  = (state_q == ST_E_SP) || (state_q == ST_R_FP);
    assign beat_step = mem_req && mem_ready;
    assign sp_load   = beat_clr;
    assign sp_load_val = (state_q == ST_R_FP) ? rf_rdata + FRAME_SPAN : rf_rdata;
    assign sp_up     = (state_q == ST_E_PUSH) && mem_ready;
    assign sp_down   = (state_q == ST_R_POP) && mem_ready;

    irq_ctx_beat #(.COUNT(FRAME_WORDS), .W(SLOT_W)) i_beat (
        .clk  (clk),
        .rst  (rst),
        .clr  (beat_clr),
        .step (beat_step),
        .cnt  (beat_cnt),
        .last (beat_last)
    );

    irq_ctx_sp #(.W(XLEN), .STEP(WORD_BYTES)) i_sp (
        .clk      (clk),
        .rst      (rst),
        .load     (sp_load),
        .load_val (sp_load_val),
        .up       (sp_up),
        .down     (sp_down),
        .sp       (sp_cur),
        .sp_below (sp_below)
    );

    // Register file read selection
    always_comb begin
        case (state_q)
            ST_E_SP:   rf_raddr = SEL_SP;
            ST_E_PUSH: rf_raddr = slot_sel(beat_cnt);
            ST_R_FP:   rf_raddr = SEL_FP;
            default:   rf_raddr = '0;
        endcase
    end

    // Register file write selection
    always_comb begin
        wr = '0;
        case (state_q)
            ST_E_SETSP: wr = '{we: 1'b1, sel: SEL_SP, data: sp_cur};
            ST_E_SETFP: wr = '{we: 1'b1, sel: SEL_FP, data: sp_cur - FRAME_SPAN};
            ST_E_SETIP: wr = '{we: 1'b1, sel: SEL_IP, data: hnd_q};
            ST_E_SETR0: wr = '{we: 1'b1, sel: rsel_t'(0), data: XLEN'(idx_q)};
            ST_E_SETR1: wr = '{we: 1'b1, sel: rsel_t'(1), data: aux_q};
            ST_R_POP: begin
                wr.we   = mem_ready;
                wr.sel  = slot_sel(SLOT_W'(FRAME_WORDS - 1) - beat_cnt);
                wr.data = mem_rdata;
            end
            ST_R_SETSP: wr = '{we: 1'b1, sel: SEL_SP, data: sp_cur};
            default:    wr = '0;
        endcase
    end

    assign rf_we    = wr.we;
    assign rf_waddr = wr.sel;
    assign rf_wdata = wr.data;

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    // ---------------- assertions ----------------
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we && !done));

    p_push_ascend_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_E_PUSH && mem_ready && !beat_last)
        |=> (mem_addr == $past(mem_addr) + WORD_STEP));

    p_fp_frame_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_E_SETFP)
        |-> ($past(rf_we) && $past(rf_waddr) == SEL_SP &&
             rf_wdata == $past(rf_wdata) - FRAME_SPAN));

    p_no_wr_in_save_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !rf_we);

    p_pop_descend_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_R_POP && mem_ready && !beat_last)
        |=> (mem_addr == $past(mem_addr) - WORD_STEP));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_entry_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && entry_start) |=> (state_q == ST_E_SP));

endmodule

// File: tb/test_irq_ctx_seq.sv
module test_irq_ctx_seq;
    import irq_ctx_pkg::*;

    localparam int IDX_W = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              entry_start = 1'b0, ret_start = 1'b0;
    logic [IDX_W-1:0]  irq_index = '0;
    logic [63:0]       irq_aux = '0, handler_addr = '0, next_ip = '0;
    logic              busy, done, mem_req, mem_we, mem_ready = 1'b1;
    logic [63:0]       mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [5:0]        rf_raddr, rf_waddr;
    logic              rf_we;

    always #5 clk = ~clk;

    irq_ctx_seq #(.IDX_W(IDX_W)) i_irq_ctx_seq (
        .clk(clk), .rst(rst), .entry_start(entry_start), .ret_start(ret_start),
        .irq_index(irq_index), .irq_aux(irq_aux), .handler_addr(handler_addr),
        .next_ip(next_ip), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // ---------------- memory and register file models ----------------
    logic [63:0] rf_m  [0:36];
    logic [63:0] mem_m [0:511];
    logic        poke_rf = 1'b0, poke_mem = 1'b0;
    logic [8:0]  poke_addr = '0;
    logic [63:0] poke_data = '0;

    assign rf_rdata  = (rf_raddr <= 6'd36) ? rf_m[rf_raddr] : 64'd0;
    assign mem_rdata = mem_m[mem_addr[11:3]];

    always @(posedge clk) begin
        if (rf_we && rf_waddr <= 6'd36) rf_m[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ready && mem_we) mem_m[mem_addr[11:3]] <= mem_wdata;
        if (poke_rf)  rf_m[poke_addr[5:0]] <= poke_data;
        if (poke_mem) mem_m[poke_addr]     <= poke_data;
    end

    // ---------------- ready pattern ----------------
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = !stall_en || (lfsr[1:0] != 2'b00);
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int          kind;   // 0 mem write, 1 mem read, 2 register write
        logic [63:0] addr;
        logic [63:0] data;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void expect_item(input int k, input logic [63:0] a,
                                        input logic [63:0] d, input string t);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.tag = t;
        exp_q.push_back(it);
    endfunction

    task automatic observe(input int k, input logic [63:0] a, input logic [63:0] d);
        item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7", a, 64'hX, $sformatf("unexpected event kind %0d", k));
            return;
        end
        it = exp_q.pop_front();
        check(it.kind == k, it.tag, 64'(k), 64'(it.kind), "event kind");
        check(it.addr == a, it.tag, a, it.addr, "address/selector");
        if (k != 1) check(it.data == d, it.tag, d, it.data, "data");
    endtask

    logic        stalled = 1'b0;
    logic [63:0] st_addr;
    logic        st_we;

    always @(negedge clk) begin
        if (!rst) begin
            if (stalled) begin
                check(mem_req, "R5", 64'(mem_req), 64'd1, "request dropped in stall");
                check(mem_addr == st_addr && mem_we == st_we, "R5", mem_addr, st_addr,
                      "request changed in stall");
            end
            stalled = mem_req && !mem_ready;
            st_addr = mem_addr;
            st_we   = mem_we;
            if (mem_req && mem_ready) observe(mem_we ? 0 : 1, mem_addr, mem_wdata);
            if (rf_we) observe(2, 64'(rf_waddr), rf_wdata);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    // ---------------- driver helpers ----------------
    // Record slot -> selector, bench's own view of R2/R4 ordering.
    function automatic int bslot(input int k);
        if (k == 0) return 32;
        if (k == 1) return 36;
        if (k == 2) return 33;
        if (k == 3) return 34;
        return k - 4;
    endfunction

    task automatic poke(input bit is_mem, input logic [8:0] a, input logic [63:0] d);
        @(negedge clk);
        poke_rf = !is_mem; poke_mem = is_mem; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_rf = 1'b0; poke_mem = 1'b0;
    endtask

    // mode 0 plain, 1 both starts together, 2 extra starts injected while busy
    task automatic start_seq(input bit e, input bit r, input int mode);
        @(negedge clk);
        entry_start = e || (mode == 1);
        ret_start   = r || (mode == 1);
        @(negedge clk);
        entry_start = 1'b0; ret_start = 1'b0;
        check(busy, "R6", 64'(busy), 64'd1, "busy after accept");
        if (mode == 2) begin
            repeat (6) @(negedge clk);
            entry_start = 1'b1; ret_start = 1'b1;
            @(negedge clk);
            entry_start = 1'b0; ret_start = 1'b0;
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'd0, "items left at done");
        @(negedge clk);
        check(!done && !busy, "R6", {62'd0, done, busy}, 64'd0, "done pulse width / idle");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && !busy, "R7", 64'(exp_q.size()), 64'd0,
              "no sequence after ignored start");
    endtask

    task automatic run_entry(input logic [IDX_W-1:0] idx, input logic [63:0] aux,
                             input logic [63:0] hnd, input logic [63:0] nip, input int mode);
        logic [63:0] sp0;
        sp0 = rf_m[35];
        for (int k = 0; k < 36; k++)
            expect_item(0, sp0 + 64'(8 * k), (k == 1) ? nip : rf_m[bslot(k)], "R2");
        expect_item(2, 64'd35, sp0 + 64'd288, "R3");
        expect_item(2, 64'd32, sp0, "R3");
        expect_item(2, 64'd36, hnd, "R3");
        expect_item(2, 64'd0, 64'(idx), "R3");
        expect_item(2, 64'd1, aux, "R3");
        irq_index = idx; irq_aux = aux; handler_addr = hnd; next_ip = nip;
        start_seq(1'b1, 1'b0, mode);
        wait_done();
    endtask

    task automatic run_return(input int mode);
        logic [63:0] fp0, a;
        fp0 = rf_m[32];
        for (int j = 0; j < 36; j++) begin
            a = fp0 + 64'd288 - 64'(8 * (j + 1));
            expect_item(1, a, 64'd0, "R4");
            expect_item(2, 64'(bslot(35 - j)), mem_m[a[11:3]], "R4");
        end
        expect_item(2, 64'd35, fp0, "R4");
        irq_handler_scramble();
        start_seq(1'b0, 1'b1, mode);
        wait_done();
    endtask

    // nothing to scramble through ports; kept as a no-op marker of handler time
    task automatic irq_handler_scramble();
        @(negedge clk);
    endtask

    logic [63:0] snap [0:36];
    task automatic take_snap();
        for (int r = 0; r <= 36; r++) snap[r] = rf_m[r];
    endtask

    task automatic compare_snap(input logic [63:0] nip, input string tag);
        for (int r = 0; r <= 36; r++)
            check(rf_m[r] == ((r == 36) ? nip : snap[r]), tag, rf_m[r],
                  (r == 36) ? nip : snap[r], $sformatf("register %0d after return", r));
    endtask

    // ---------------- main sequence ----------------
    initial begin
        rst = 1'b1;
        for (int r = 0; r <= 36; r++)
            poke(1'b0, 9'(r), 64'hC0DE_0000_0000_0000 | 64'(r * 32'h0101_1111));
        poke(1'b0, 9'd35, 64'h200);
        poke(1'b0, 9'd32, 64'h1F0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req && !rf_we, "R1",
              {60'd0, busy, done, mem_req, rf_we}, 64'd0, "outputs after reset");
        repeat (4) @(negedge clk);
        check(!busy && !done && !mem_req && !rf_we, "R1",
              {60'd0, busy, done, mem_req, rf_we}, 64'd0, "outputs while idle");

        // plain entry and return
        take_snap();
        run_entry(9'h1A5, 64'hAAAA_5555_1234_0001, 64'h4000, 64'h1008, 0);
        run_return(0);
        compare_snap(64'h1008, "R4");

        // same under random stalls
        stall_en = 1'b1;
        take_snap();
        run_entry(9'h003, 64'h0, 64'h5000, 64'h2222, 0);
        run_return(0);
        compare_snap(64'h2222, "R4");

        // nested entries (R9)
        take_snap();
        run_entry(9'h080, 64'hFEED, 64'h6000, 64'h3000, 0);
        check(rf_m[35] == snap[35] + 64'd288, "R9", rf_m[35], snap[35] + 64'd288, "first frame top");
        run_entry(9'h1FF, 64'hBEEF, 64'h7000, 64'h6010, 0);
        check(rf_m[35] == snap[35] + 64'd576, "R9", rf_m[35], snap[35] + 64'd576, "second frame top");
        run_return(0);
        run_return(0);
        compare_snap(64'h3000, "R9");

        // return from a record planted in memory
        stall_en = 1'b0;
        poke(1'b0, 9'd32, 64'h800);
        for (int k = 0; k < 36; k++)
            poke(1'b1, 9'(9'h100 + k), 64'h9000_0000_0000_0000 | 64'(k * 7 + 3));
        run_return(0);
        check(rf_m[35] == 64'h800, "R4", rf_m[35], 64'h800, "stack pointer after return");

        // simultaneous starts: entry wins
        stall_en = 1'b1;
        poke(1'b0, 9'd35, 64'h200);
        take_snap();
        run_entry(9'h011, 64'h77, 64'h8000, 64'h4444, 1);
        run_return(0);
        compare_snap(64'h4444, "R8");

        // starts injected while busy are ignored
        take_snap();
        run_entry(9'h022, 64'h99, 64'h8800, 64'h5555, 2);
        run_return(2);
        compare_snap(64'h5555, "R7");

        summary();
    end

endmodule